// File: doc/BRIEF.md
# Port-Pin Boundary-Scan Cell Chain

This block sits between a core's bidirectional port signals and the pads, one group of four scan cells per pin. The TAP controller supplies the capture, shift and update strobes, all synchronous to TCK, and an external-test flag. The chain carries test data serially from `scan_in` to `scan_out`. When the flag is low, the pads follow the core. When the flag is high, they follow a bank of update latches that the chain loads.

Each pin owns four cells: input level, output data, output enable and pull-up disable. Pin 0 is nearest the serial output. On a capture, the chain samples the pad input level and the drive the core presents. On a shift, the chain moves one place toward the serial output. An update copies the chain into the latches on the falling TCK edge. The latched values reach the pads as soon as the external-test flag rises, without waiting for a new update.

Top module: `pin_scan_chain`

## Requirements
- R1: An active-low `rst_n` clears every shift stage and every update latch. With `extest` high after reset, every pad has output enable 0, output data 0 and pull-up enable 1, and a shift with no capture returns only zeros.
- R2: On a rising TCK with `capture_dr` high, the chain loads these values for each pin p: bit 4p gets `pad_di[p]`, bit 4p+1 gets `core_do[p]`, bit 4p+2 gets `core_oe[p]`, and bit 4p+3 gets the inverse of `core_pue[p]`.
- R3: On a rising TCK with `shift_dr` high and `capture_dr` low, bit i takes bit i+1, and the top bit (4N-1) takes `scan_in`. `scan_out` always shows bit 0, so data leaves LSB first and re-emerges after 4N shifts.
- R4: On a falling TCK with `update_dr` high, every update latch loads the corresponding chain bit.
- R5: While `extest` is high, each pad p takes its output data from latch bit 4p+1 and its output enable from latch bit 4p+2. Its pull-up enable is the inverse of latch bit 4p+3. The pads change on the same cycle `extest` rises, with no clock edge.
- R6: While `extest` is low, `pad_do`, `pad_oe` and `pad_pue` equal `core_do`, `core_oe` and `core_pue`.
- R7: The update latches keep their value on every falling TCK with `update_dr` low, whatever shifting or capturing goes on.
- R8: `core_di` always equals `pad_di`.
- R9: When `capture_dr` and `shift_dr` are both high, capture wins. With both low, the chain holds its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test reset |
| scan_in | input | 1 | Serial test data in |
| capture_dr | input | 1 | Capture strobe from the TAP |
| shift_dr | input | 1 | Shift strobe from the TAP |
| update_dr | input | 1 | Update strobe from the TAP |
| extest | input | 1 | External-test instruction active |
| core_pue | input | NPINS | Core pull-up enable per pin |
| core_oe | input | NPINS | Core output enable per pin |
| core_do | input | NPINS | Core output data per pin |
| core_di | output | NPINS | Pad level passed to the core |
| pad_di | input | NPINS | Level seen on each pad |
| pad_pue | output | NPINS | Pull-up enable to each pad |
| pad_oe | output | NPINS | Output enable to each pad |
| pad_do | output | NPINS | Output data to each pad |
| scan_out | output | 1 | Serial test data out |

## Verification
A capture or a shift shows up at `scan_out` after the next rising TCK. The bench therefore changes the strobes 3 ns after a rising edge and reads `scan_out` at that same point before the next one. An update takes effect at the falling edge inside the strobe's cycle, so pads are checked only after the following rising edge has passed. The pad mux is purely combinational: the `extest` and core-follow checks read the pads 1 ns after the input changes, before any clock edge.

// File: rtl/pin_scan_chain.sv
module pin_scan_chain #(
  parameter int NPINS = 4
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             scan_in,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             extest,
  input  logic [NPINS-1:0] core_pue,
  input  logic [NPINS-1:0] core_oe,
  input  logic [NPINS-1:0] core_do,
  output logic [NPINS-1:0] core_di,
  input  logic [NPINS-1:0] pad_di,
  output logic [NPINS-1:0] pad_pue,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_do,
  output logic             scan_out
);
  localparam int LEN = 4 * NPINS;

  logic [LEN-1:0] sh_q, upd_q, cap;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign cap[4*p]   = pad_di[p];
    assign cap[4*p+1] = core_do[p];
    assign cap[4*p+2] = core_oe[p];
    assign cap[4*p+3] = ~core_pue[p];
    assign pad_do[p]  = extest ? upd_q[4*p+1]  : core_do[p];
    assign pad_oe[p]  = extest ? upd_q[4*p+2]  : core_oe[p];
    assign pad_pue[p] = extest ? ~upd_q[4*p+3] : core_pue[p];
  end

  assign core_di  = pad_di;
  assign scan_out = sh_q[0];

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n)          sh_q <= '0;
    else if (capture_dr) sh_q <= cap;
    else if (shift_dr)   sh_q <= {scan_in, sh_q[LEN-1:1]};

  always_ff @(negedge tck or negedge rst_n)
    if (!rst_n)         upd_q <= '0;
    else if (update_dr) upd_q <= sh_q;

  p_capture_r2: assert property (@(posedge tck) disable iff (!rst_n)
    capture_dr |=> sh_q == $past(cap));

  p_shift_r3: assert property (@(posedge tck) disable iff (!rst_n)
    (shift_dr && !capture_dr) |=> sh_q == {$past(scan_in), $past(sh_q[LEN-1:1])});

  p_idle_hold_r9: assert property (@(posedge tck) disable iff (!rst_n)
    (!shift_dr && !capture_dr) |=> $stable(sh_q));

  p_update_load_r4: assert property (@(negedge tck) disable iff (!rst_n)
    update_dr |=> upd_q == $past(sh_q));

  p_latch_hold_r7: assert property (@(negedge tck) disable iff (!rst_n)
    !update_dr |=> $stable(upd_q));
endmodule

// File: tb/pin_scan_chain_tb.sv
`timescale 1ns/1ps
module pin_scan_chain_tb;
  localparam int N = 4;
  localparam int L = 4 * N;

  logic tck = 1'b0, rst_n = 1'b0, scan_in = 1'b0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, extest = 1'b0;
  logic [N-1:0] core_pue = '0, core_oe = '0, core_do = '0, pad_di = '0;
  logic [N-1:0] core_di, pad_pue, pad_oe, pad_do;
  logic scan_out;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  pin_scan_chain #(.NPINS(N)) u_dut (
    .tck, .rst_n, .scan_in, .capture_dr, .shift_dr, .update_dr, .extest,
    .core_pue, .core_oe, .core_do, .core_di, .pad_di,
    .pad_pue, .pad_oe, .pad_do, .scan_out
  );

  always #10 tck = ~tck;

  function automatic logic [L-1:0] exp_cap(logic [N-1:0] di, logic [N-1:0] dout,
                                           logic [N-1:0] oe, logic [N-1:0] pue);
    logic [L-1:0] v;
    for (int p = 0; p < N; p++) begin
      v[4*p] = di[p]; v[4*p+1] = dout[p]; v[4*p+2] = oe[p]; v[4*p+3] = ~pue[p];
    end
    return v;
  endfunction

  function automatic logic [3*N-1:0] exp_pads(logic [L-1:0] v);
    logic [N-1:0] d, o, u;
    for (int p = 0; p < N; p++) begin
      d[p] = v[4*p+1]; o[p] = v[4*p+2]; u[p] = ~v[4*p+3];
    end
    return {u, o, d};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic scan(input bit cap, input logic [L-1:0] din, output logic [L-1:0] dout);
    if (cap) begin
      capture_dr = 1'b1;
      @(posedge tck); #3;
      capture_dr = 1'b0;
    end
    shift_dr = 1'b1;
    for (int i = 0; i < L; i++) begin
      scan_in = din[i];
      dout[i] = scan_out;
      @(posedge tck); #3;
    end
    shift_dr = 1'b0;
  endtask

  task automatic update();
    update_dr = 1'b1;
    @(posedge tck); #3;
    update_dr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [L-1:0] d0, d1, got, cexp;
    void'($urandom(32'h5eed_2024));
    repeat (3) @(posedge tck);
    #3 rst_n = 1'b1;
    @(posedge tck); #3;

    // R1 reset state
    extest = 1'b1; #1;
    chk("R1 pads", {pad_pue, pad_oe, pad_do}, {{N{1'b1}}, {N{1'b0}}, {N{1'b0}}});
    extest = 1'b0;
    scan(1'b0, '0, got);
    chk("R1 chain", got, '0);

    // R9 capture beats shift
    core_do = 4'b1010; core_oe = 4'b0110; core_pue = 4'b1100; pad_di = 4'b0011;
    cexp = exp_cap(pad_di, core_do, core_oe, core_pue);
    capture_dr = 1'b1; shift_dr = 1'b1; scan_in = 1'b1;
    @(posedge tck); #3;
    capture_dr = 1'b0; shift_dr = 1'b0;
    repeat (3) @(posedge tck);
    #3;
    scan(1'b0, 16'hA5C3, got);
    chk("R9 priority+hold", got, cexp);

    // R9 idle hold of shifted-in data
    repeat (4) @(posedge tck);
    #3;
    scan(1'b0, '0, got);
    chk("R9 idle hold", got, 16'hA5C3);

    // Directed corners: all ones, all zeros, walking pattern
    for (int k = 0; k < 3; k++) begin
      d0 = (k == 0) ? '1 : (k == 1) ? '0 : 16'h8001;
      scan(1'b0, d0, got);
      update();
      extest = 1'b1; #1;
      chk("R5 corner", {pad_pue, pad_oe, pad_do}, exp_pads(d0));
      extest = 1'b0; #1;
    end

    for (int it = 0; it < 40; it++) begin
      core_do = N'($urandom); core_oe = N'($urandom);
      core_pue = N'($urandom); pad_di = N'($urandom);
      d0 = L'($urandom); d1 = L'($urandom);
      extest = 1'b0; #1;
      chk("R6 follow core", {pad_pue, pad_oe, pad_do}, {core_pue, core_oe, core_do});
      chk("R8 input path", core_di, pad_di);
      cexp = exp_cap(pad_di, core_do, core_oe, core_pue);
      scan(1'b1, d0, got);
      chk("R2 capture", got, cexp);
      update();
      chk("R6 still core", {pad_pue, pad_oe, pad_do}, {core_pue, core_oe, core_do});
      extest = 1'b1; #1;
      chk("R5 immediate", {pad_pue, pad_oe, pad_do}, exp_pads(d0));
      scan(1'b0, d1, got);
      chk("R3 shift path", got, d0);
      chk("R7 latch hold", {pad_pue, pad_oe, pad_do}, exp_pads(d0));
      update();
      chk("R4 update", {pad_pue, pad_oe, pad_do}, exp_pads(d1));
    end

    // R1 reset clears latches mid-run
    rst_n = 1'b0; #1;
    chk("R1 async", {pad_pue, pad_oe, pad_do}, {{N{1'b1}}, {N{1'b0}}, {N{1'b0}}});
    @(posedge tck); #3 rst_n = 1'b1;
    @(posedge tck); #3;
    finish_run();
  end
endmodule